// File: doc/BRIEF.md
# Repeat-Flow Record Merger

This block takes a stream of flow records in batches. Each record carries a flag naming which buffer its batch came from. Records from the new-flow buffer go straight to the output stream and never touch storage. Records from the repeat-flow buffer go one at a time into a small direct-mapped table, indexed by a fold of the flow key.

When a record arrives, one of three things happens in its bucket:
- If the bucket holds the same key, the two records are combined.
- If the bucket is empty, the record is stored there.
- If the bucket holds another key, the resident record is pushed to the output and the arriving record takes its place.

A flush command walks the table and emits every stored record. This is used at the end of a measurement interval.

Records leave on a single valid/ready stream, in the order the block produces them. Backpressure on that stream stalls any step that needs to emit. It then stalls the input.

Top module: `flow_merge_table`

## Requirements
- R1: A record with `in_repeat`=0 is emitted with key, count and both timestamps unchanged, and the table contents stay as they were.
- R2: A repeat record uses bucket index `in_key[IDX_W-1:0] ^ in_key[2*IDX_W-1:IDX_W]` (bits 2:0 XOR bits 5:3 with the defaults).
- R3: A repeat record that lands in an empty bucket is stored there and produces no output.
- R4: A repeat record whose key matches the resident key is merged into that bucket and produces no output. The merge sums the counts modulo 2^CNT_W, keeps the smaller start timestamp and keeps the larger end timestamp.
- R5: A repeat record whose key differs from a valid resident record causes the resident record to be emitted. The incoming record then replaces it.
- R6: Each accepted record deasserts `in_ready` for the following cycle (two cycles per record). `in_ready` stays low while an emit waits for a free output.
- R7: A `flush` pulse emits every valid bucket in ascending index order and leaves the table empty. `in_ready` is low from the cycle after the pulse until the walk ends.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and the record fields hold. Records leave in the order they were produced.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and every bucket is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Block can accept a record |
| in_repeat | input | 1 | 1 = repeat-flow batch, 0 = new-flow batch |
| in_key | input | KEY_W | Flow key |
| in_cnt | input | CNT_W | Packet count |
| in_tstart | input | TS_W | First-packet timestamp |
| in_tend | input | TS_W | Last-packet timestamp |
| flush | input | 1 | Pulse: drain the table |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream accepts record |
| out_key | output | KEY_W | Emitted key |
| out_cnt | output | CNT_W | Emitted count |
| out_tstart | output | TS_W | Emitted start timestamp |
| out_tend | output | TS_W | Emitted end timestamp |

## Verification
- An accepted record is registered at the accept edge. Its table update or emit happens at the next edge, provided the output register is free.
- An emitted record shows on the output one cycle after that decision.
- `in_ready` is sampled at the falling edge after acceptance and must then be low.
- After a flush pulse, `in_ready` is sampled low at the next falling edge.
- Output records are compared at falling edges where valid and ready are both high, against a queue built from the requirements. This makes the checks independent of exact latency while backpressure varies.

// File: rtl/flow_merge_table.sv
module flow_merge_table #(
  parameter int KEY_W = 8,
  parameter int CNT_W = 12,
  parameter int TS_W  = 12,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_repeat,
  input  logic [KEY_W-1:0] in_key,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [TS_W-1:0]  in_tstart,
  input  logic [TS_W-1:0]  in_tend,
  input  logic             flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [CNT_W-1:0] out_cnt,
  output logic [TS_W-1:0]  out_tstart,
  output logic [TS_W-1:0]  out_tend
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WORK, ST_FLUSH} st_t;
  st_t st;

  logic [DEPTH-1:0] tv;
  logic [KEY_W-1:0] tk [DEPTH];
  logic [CNT_W-1:0] tc [DEPTH];
  logic [TS_W-1:0]  ts [DEPTH];
  logic [TS_W-1:0]  te [DEPTH];

  logic             h_rep, fl_pend;
  logic [KEY_W-1:0] h_key;
  logic [CNT_W-1:0] h_cnt;
  logic [TS_W-1:0]  h_ts, h_te;
  logic [IDX_W-1:0] fptr;

  wire [IDX_W-1:0] hidx = h_key[IDX_W-1:0] ^ h_key[2*IDX_W-1:IDX_W];
  wire out_free = !out_valid || out_ready;
  wire work     = (st == ST_WORK);
  wire hit      = tv[hidx] && (tk[hidx] == h_key);
  wire col      = work && h_rep && tv[hidx] && !hit;
  wire emit_bp  = work && !h_rep && out_free;
  wire emit_col = col && out_free;
  wire emit_fl  = (st == ST_FLUSH) && tv[fptr] && out_free;
  wire store    = work && h_rep && (!col || out_free);
  wire load     = emit_bp || emit_col || emit_fl;

  assign in_ready = (st == ST_IDLE) && !fl_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      tv <= '0;
      fl_pend <= 1'b0;
      fptr <= '0;
      out_valid <= 1'b0;
    end else begin
      if (flush) fl_pend <= 1'b1;
      if (load) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      case (st)
        ST_IDLE:
          if (fl_pend) begin
            st <= ST_FLUSH;
            fptr <= '0;
            fl_pend <= flush;
          end else if (in_valid) st <= ST_WORK;
        ST_WORK:
          if (emit_bp || store) st <= ST_IDLE;
        ST_FLUSH:
          if (!tv[fptr] || out_free) begin
            tv[fptr] <= 1'b0;
            fptr <= fptr + 1'b1;
            if (fptr == IDX_W'(DEPTH - 1)) st <= ST_IDLE;
          end
        default: st <= ST_IDLE;
      endcase
      if (store) tv[hidx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      h_rep <= in_repeat;
      h_key <= in_key;
      h_cnt <= in_cnt;
      h_ts  <= in_tstart;
      h_te  <= in_tend;
    end
    if (store) begin
      tk[hidx] <= h_key;
      if (hit) begin
        tc[hidx] <= tc[hidx] + h_cnt;
        if (h_ts < ts[hidx]) ts[hidx] <= h_ts;
        if (h_te > te[hidx]) te[hidx] <= h_te;
      end else begin
        tc[hidx] <= h_cnt;
        ts[hidx] <= h_ts;
        te[hidx] <= h_te;
      end
    end
    if (emit_bp) begin
      out_key <= h_key; out_cnt <= h_cnt; out_tstart <= h_ts; out_tend <= h_te;
    end else if (emit_col) begin
      out_key <= tk[hidx]; out_cnt <= tc[hidx]; out_tstart <= ts[hidx]; out_tend <= te[hidx];
    end else if (emit_fl) begin
      out_key <= tk[fptr]; out_cnt <= tc[fptr]; out_tstart <= ts[fptr]; out_tend <= te[fptr];
    end
  end

  AST_BYPASS_NO_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (work && !h_rep) |=> $stable(tv)); // R1
  AST_ONE_PER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R6
  AST_FLUSH_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH) |-> !in_ready); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_cnt)
                                   && $stable(out_tstart) && $stable(out_tend))); // R8
  AST_MERGE_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (work && h_rep && tv[hidx] && hit && out_valid && !out_ready) |=> out_valid && $stable(out_key)); // R4
endmodule

// File: tb/test_flow_merge_table.sv
module test_flow_merge_table;
  localparam int KW = 8, CW = 12, TW = 12, IW = 3, D = 8;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_repeat = 0, flush = 0, out_ready = 0;
  logic [KW-1:0] in_key = '0;
  logic [CW-1:0] in_cnt = '0;
  logic [TW-1:0] in_tstart = '0, in_tend = '0;
  logic in_ready, out_valid;
  logic [KW-1:0] out_key;
  logic [CW-1:0] out_cnt;
  logic [TW-1:0] out_tstart, out_tend;

  flow_merge_table #(.KEY_W(KW), .CNT_W(CW), .TS_W(TW), .IDX_W(IW)) i_flow_merge_table (
    .clk, .rst_n, .in_valid, .in_ready, .in_repeat, .in_key, .in_cnt, .in_tstart, .in_tend,
    .flush, .out_valid, .out_ready, .out_key, .out_cnt, .out_tstart, .out_tend);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, bp_mode = 0;
  bit mv [D];
  logic [KW-1:0] mk [D];
  logic [CW-1:0] mc [D];
  logic [TW-1:0] ms [D], me [D];
  logic [KW+CW+2*TW-1:0] q [1024];
  int qh = 0, qt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic push(input logic [KW-1:0] k, input logic [CW-1:0] c, input logic [TW-1:0] s, input logic [TW-1:0] e);
    q[qt % 1024] = {k, c, s, e}; qt++;
  endtask

  always @(posedge clk) begin
    cyc++;
    #2 case (bp_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3) != 0;
      default: out_ready <= (cyc % 7) == 0;
    endcase
  end

  // R8: order and content of every transfer checked against the model queue
  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    if (qh == qt) chk(0, "R8 unexpected record", longint'(out_key), 0);
    else begin
      chk({out_key, out_cnt, out_tstart, out_tend} == q[qh % 1024], "R1/R4/R5/R7/R8 record",
          longint'({out_key, out_cnt, out_tstart, out_tend}), longint'(q[qh % 1024]));
      qh++;
    end
  end

  task automatic send(input bit rep, input logic [KW-1:0] k, input logic [CW-1:0] c,
                      input logic [TW-1:0] s, input logic [TW-1:0] e);
    int i;
    @(negedge clk);
    in_valid = 1; in_repeat = rep; in_key = k; in_cnt = c; in_tstart = s; in_tend = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R6 in_ready low after accept", in_ready, 0);
    i = int'(k[2:0] ^ k[5:3]); // R2
    if (!rep) push(k, c, s, e); // R1
    else if (!mv[i]) begin mv[i] = 1; mk[i] = k; mc[i] = c; ms[i] = s; me[i] = e; end // R3
    else if (mk[i] == k) begin // R4
      mc[i] = mc[i] + c;
      if (s < ms[i]) ms[i] = s;
      if (e > me[i]) me[i] = e;
    end else begin // R5
      push(mk[i], mc[i], ms[i], me[i]);
      mk[i] = k; mc[i] = c; ms[i] = s; me[i] = e;
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk(in_ready == 0, "R7 in_ready low after flush", in_ready, 0);
    for (int i = 0; i < D; i++) if (mv[i]) begin push(mk[i], mc[i], ms[i], me[i]); mv[i] = 0; end
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < D; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R9 in_ready after reset", in_ready, 1);
    do_flush(); // R9: empty table emits nothing
    for (int m = 0; m < 3; m++) begin
      bp_mode = m;
      for (int k = 0; k < 64; k++)
        send(1, KW'(k), CW'(k * 3 + m + 1), TW'((k * 37 + m * 11) % 4096), TW'(1000 + k * 5));
      for (int k = 0; k < 64; k += 5)
        send(0, KW'(k), CW'(k + 7), TW'(k), TW'(k + 9));
      for (int k = 56; k < 64; k++)
        send(1, KW'(k), CW'(4095 - k), TW'(k * 2 + m), TW'(2000 + k * m));
      for (int k = 0; k < 64; k += 9)
        send(1, KW'(k), CW'(k + 2), TW'(k), TW'(k + 1));
      for (int k = 0; k < 64; k++)
        send(1, KW'(k), CW'(k), TW'(k), TW'(k));
      do_flush();
    end
    for (int n = 0; n < 2000 && qh != qt; n++) @(negedge clk);
    chk(qh == qt, "R7/R8 all records drained", qt - qh, 0);
    chk(out_valid == 0, "R7 output idle at end", out_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule